// File: doc/BRIEF.md
# Address Breakpoint and Single-Step Unit

This unit watches a processor's 24-bit fetch address and raises a break request that halts the core for an attached debugger. It has two comparators. Each one holds a three-byte reference address, has its own enable, and has its own option to mask the low address byte. With the mask on, a comparator fires anywhere inside a 256-byte page. A single-step mode also requests a break each time the core signals that an instruction has finished.

The debugger programs the unit through a byte-wide write port with a 3-bit register select. The core supplies the address, a fetch-valid qualifier and an instruction-complete strobe. Once a break is requested it is latched and stays asserted until the debugger pulses resume. A cause field records which comparators fired and whether single-step fired, so the debugger can tell why the core stopped.

Top module: `addr_brk_unit`

## Requirements
- R1: With its mask bit clear, an enabled comparator fires only when all 24 bits of `addr_i` equal its reference {upper, high, low}.
- R2: With its mask bit set, an enabled comparator compares only `addr_i[23:8]` against its upper and high bytes, so any low byte matches.
- R3: A comparator whose enable bit is 0 never fires. Its cause bit stays 0 whatever address is presented.
- R4: Register select codes are fixed. Codes 0, 1 and 2 are the low, high and upper bytes of comparator 0. Codes 3, 4 and 5 are the same bytes of comparator 1. Code 6 is control, with bit 0 for single-step, bit 1 for comparator 0 mask, bit 2 for comparator 1 mask, bit 3 for comparator 0 enable and bit 4 for comparator 1 enable. Each mask bit affects only its own comparator.
- R5: With single-step set, every `instr_done_i` pulse requests a break and sets `brk_step_o`. After a resume, the next break needs a new `instr_done_i` pulse. With single-step clear, `instr_done_i` has no effect.
- R6: Address comparison takes effect only in cycles where `fetch_vld_i` is 1.
- R7: Once asserted, `brk_o` stays at 1 until `resume_i` is pulsed. A resume in the same cycle as a new firing source leaves `brk_o` at 1.
- R8: Sources that fire together raise one break. `brk_cause_o[k]` is 1 when comparator k fired. While a break is held, causes from further sources are added. A resume that coincides with new sources keeps only the new causes. The cause bits and `brk_step_o` are 0 whenever `brk_o` is 0.
- R9: After reset, all registers are zero and `brk_o`, `brk_cause_o` and `brk_step_o` are 0.
- R10: A source that fires in cycle n shows on `brk_o` after the clock edge that ends cycle n, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select code |
| reg_wdata_i | input | 8 | Register write data |
| addr_i | input | 24 | Processor fetch address |
| fetch_vld_i | input | 1 | Qualifies `addr_i` |
| instr_done_i | input | 1 | Instruction-complete strobe |
| resume_i | input | 1 | Clears a held break |
| brk_o | output | 1 | Break request to the core |
| brk_cause_o | output | 2 | Comparators that caused the break |
| brk_step_o | output | 1 | Single-step caused the break |

## Verification
The assertions check these rules on every cycle: a full match, a page match and a finished step each produce a break one cycle later; a break holds until resume; no break appears without a qualified source; held causes are never lost; and the cause bits are clear whenever there is no break. Some behaviour shows only in the bench scenarios. These are the decode of each select code and control bit position, the mask acting on only one comparator, an address one past the reference being rejected, a resume losing to a coinciding event, and the cause field collecting sources while a break is held.

// File: rtl/addr_brk_pkg.sv
package addr_brk_pkg;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned N_CMP  = 2;
  localparam int unsigned SEL_W  = 3;
endpackage

// File: rtl/brk_regs.sv
module brk_regs #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned N_CMP  = 2,
  parameter int unsigned SEL_W  = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [SEL_W-1:0]               sel_i,
  input  logic [7:0]                     wdata_i,
  output logic [N_CMP-1:0][ADDR_W-1:0]   ref_o,
  output logic [N_CMP-1:0]               en_o,
  output logic [N_CMP-1:0]               ign_o,
  output logic                           step_o
);
  localparam int unsigned NB       = ADDR_W / 8;
  localparam int unsigned N_BYTES  = N_CMP * NB;
  localparam int unsigned CTRL_SEL = N_BYTES;
  localparam int unsigned CTRL_W   = 1 + 2 * N_CMP;

  logic [7:0]        byte_q [N_BYTES];
  logic [CTRL_W-1:0] ctrl_q;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               byte_q[g] <= '0;
      else if (we_i && sel_i == SEL_W'(g))       byte_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 ctrl_q <= '0;
    else if (we_i && sel_i == SEL_W'(CTRL_SEL))  ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  // byte 0 of each set is the low byte
  for (genvar k = 0; k < N_CMP; k++) begin : g_ref
    for (genvar b = 0; b < NB; b++) begin : g_b
      assign ref_o[k][8*b +: 8] = byte_q[k*NB + b];
    end
  end

  assign step_o = ctrl_q[0];
  assign ign_o  = ctrl_q[N_CMP:1];
  assign en_o   = ctrl_q[2*N_CMP:N_CMP+1];
endmodule

// File: rtl/brk_cmp.sv
module brk_cmp #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] ref_i,
  input  logic              vld_i,
  input  logic              en_i,
  input  logic              ign_i,
  output logic              hit_o
);
  logic page_eq, low_eq;
  assign page_eq = addr_i[ADDR_W-1:8] == ref_i[ADDR_W-1:8];
  assign low_eq  = addr_i[7:0] == ref_i[7:0];
  assign hit_o   = vld_i & en_i & page_eq & (ign_i | low_eq);
endmodule

// File: rtl/brk_latch.sv
module brk_latch #(
  parameter int unsigned N_CMP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CMP-1:0] hit_i,
  input  logic             step_en_i,
  input  logic             instr_done_i,
  input  logic             resume_i,
  output logic             brk_o,
  output logic [N_CMP-1:0] cause_o,
  output logic             step_o
);
  logic             brk_q, step_q, hold, step_hit;
  logic [N_CMP-1:0] cause_q;

  assign step_hit = step_en_i & instr_done_i;
  // new sources win over a coinciding resume
  assign hold     = brk_q & ~resume_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q   <= 1'b0;
      cause_q <= '0;
      step_q  <= 1'b0;
    end else begin
      brk_q   <= hold | (|hit_i) | step_hit;
      cause_q <= (hold ? cause_q : '0) | hit_i;
      step_q  <= (hold & step_q) | step_hit;
    end
  end

  assign brk_o   = brk_q;
  assign cause_o = cause_q;
  assign step_o  = step_q;
endmodule

// File: rtl/addr_brk_unit.sv
module addr_brk_unit
  import addr_brk_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NC = N_CMP,
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [SW-1:0] reg_sel_i,
  input  logic [7:0]    reg_wdata_i,
  input  logic [AW-1:0] addr_i,
  input  logic          fetch_vld_i,
  input  logic          instr_done_i,
  input  logic          resume_i,
  output logic          brk_o,
  output logic [NC-1:0] brk_cause_o,
  output logic          brk_step_o
);
  logic [NC-1:0][AW-1:0] ref_q;
  logic [NC-1:0]         en_q, ign_q, hit;
  logic                  step_en_q;

  brk_regs #(.ADDR_W(AW), .N_CMP(NC), .SEL_W(SW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .sel_i  (reg_sel_i),
    .wdata_i(reg_wdata_i),
    .ref_o  (ref_q),
    .en_o   (en_q),
    .ign_o  (ign_q),
    .step_o (step_en_q)
  );

  for (genvar k = 0; k < NC; k++) begin : g_cmp
    brk_cmp #(.ADDR_W(AW)) u_cmp (
      .addr_i(addr_i),
      .ref_i (ref_q[k]),
      .vld_i (fetch_vld_i),
      .en_i  (en_q[k]),
      .ign_i (ign_q[k]),
      .hit_o (hit[k])
    );
  end

  brk_latch #(.N_CMP(NC)) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .step_en_i   (step_en_q),
    .instr_done_i(instr_done_i),
    .resume_i    (resume_i),
    .brk_o       (brk_o),
    .cause_o     (brk_cause_o),
    .step_o      (brk_step_o)
  );
endmodule

// File: rtl/addr_brk_chk.sv
module addr_brk_chk #(
  parameter int unsigned AW = 24,
  parameter int unsigned NC = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [AW-1:0]         addr_i,
  input logic                  fetch_vld_i,
  input logic                  instr_done_i,
  input logic                  resume_i,
  input logic [NC-1:0][AW-1:0] ref_q,
  input logic [NC-1:0]         en_q,
  input logic [NC-1:0]         ign_q,
  input logic                  step_en_q,
  input logic                  brk_o,
  input logic [NC-1:0]         brk_cause_o,
  input logic                  brk_step_o
);
  // R1
  full_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_vld_i && en_q[0] && !ign_q[0] && addr_i == ref_q[0] |=> brk_o && brk_cause_o[0]);

  // R2
  page_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_vld_i && en_q[1] && ign_q[1] && addr_i[AW-1:8] == ref_q[1][AW-1:8]
    |=> brk_o && brk_cause_o[1]);

  // R3
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q[0] && !(brk_o && !resume_i) |=> !brk_cause_o[0]);

  // R5
  step_break_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_q && instr_done_i |=> brk_o && brk_step_o);

  // R6
  no_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_vld_i && !(step_en_q && instr_done_i) && !(brk_o && !resume_i) |=> !brk_o);

  // R7
  hold_break_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o && !resume_i |=> brk_o);

  // R8
  cause_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o && !resume_i |=> (brk_cause_o & $past(brk_cause_o)) == $past(brk_cause_o));

  // R8
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brk_o |-> brk_cause_o == '0 && !brk_step_o);
endmodule

bind addr_brk_unit addr_brk_chk #(.AW(AW), .NC(NC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .fetch_vld_i (fetch_vld_i),
  .instr_done_i(instr_done_i),
  .resume_i    (resume_i),
  .ref_q       (ref_q),
  .en_q        (en_q),
  .ign_q       (ign_q),
  .step_en_q   (step_en_q),
  .brk_o       (brk_o),
  .brk_cause_o (brk_cause_o),
  .brk_step_o  (brk_step_o)
);

// File: tb/addr_brk_unit_test.sv
`timescale 1ns/1ps
module addr_brk_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [23:0] addr_i = '0;
  logic        fetch_vld_i = 1'b0;
  logic        instr_done_i = 1'b0;
  logic        resume_i = 1'b0;
  logic        brk_o, brk_step_o;
  logic [1:0]  brk_cause_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  addr_brk_unit uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [7:0] d);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic set_ref(int k, logic [23:0] v);
    wr(3'(k*3 + 0), v[7:0]);
    wr(3'(k*3 + 1), v[15:8]);
    wr(3'(k*3 + 2), v[23:16]);
  endtask

  task automatic cyc(logic [23:0] a, logic vld, logic dn, logic res);
    addr_i = a; fetch_vld_i = vld; instr_done_i = dn; resume_i = res;
    @(negedge clk_i);
    fetch_vld_i = 1'b0; instr_done_i = 1'b0; resume_i = 1'b0;
  endtask

  task automatic resume();
    cyc('0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    chk("R9 brk", brk_o, 0);
    chk("R9 cause", brk_cause_o, 0);
    chk("R9 step", brk_step_o, 0);
    cyc(24'h000000, 1'b1, 1'b1, 1'b0);  // zero refs, everything disabled
    chk("R9 zero regs no break", brk_o, 0);
  endtask

  task automatic t_full();
    set_ref(0, 24'h123456);
    wr(3'd6, 8'h08);                      // R4 bit3 = cmp0 enable
    addr_i = 24'h123456; fetch_vld_i = 1'b1;
    #2 chk("R10 not before edge", brk_o, 0);
    @(negedge clk_i); fetch_vld_i = 1'b0;
    chk("R1 full match brk", brk_o, 1);
    chk("R1 full match cause", brk_cause_o, 2'b01);
    resume();
    chk("R7 resume clears", brk_o, 0);
    cyc(24'h123457, 1'b1, 1'b0, 1'b0);
    chk("R1 low byte differs", brk_o, 0);
    cyc(24'h000000, 1'b1, 1'b0, 1'b0);
    chk("R3 cmp1 disabled", brk_o, 0);
  endtask

  task automatic t_fetch();
    cyc(24'h123456, 1'b0, 1'b0, 1'b0);
    chk("R6 no fetch qualifier", brk_o, 0);
  endtask

  task automatic t_page();
    wr(3'd6, 8'h0A);                      // en0 + mask0
    cyc(24'h1234FF, 1'b1, 1'b0, 1'b0);
    chk("R2 page match", brk_o, 1);
    resume();
    cyc(24'h123500, 1'b1, 1'b0, 1'b0);
    chk("R2 next page", brk_o, 0);
  endtask

  task automatic t_mask_pos();
    set_ref(1, 24'h123400);
    wr(3'd6, 8'h14);                      // en1 + mask1 (bit2)
    cyc(24'h1234AB, 1'b1, 1'b0, 1'b0);
    chk("R4 mask1 at bit2", brk_cause_o, 2'b10);
    resume();
    wr(3'd6, 8'h12);                      // en1 + mask0 only
    cyc(24'h1234AB, 1'b1, 1'b0, 1'b0);
    chk("R4 mask0 does not affect cmp1", brk_o, 0);
  endtask

  task automatic t_both_hold();
    wr(3'd6, 8'h1C);                      // en0, en1, mask1
    cyc(24'h123456, 1'b1, 1'b0, 1'b0);
    chk("R8 both cause", brk_cause_o, 2'b11);
    cyc('0, 1'b0, 1'b0, 1'b0);
    chk("R7 held idle", brk_o, 1);
    cyc(24'h1234CC, 1'b1, 1'b0, 1'b1);   // resume with new cmp1 hit
    chk("R7 resume vs event", brk_o, 1);
    chk("R8 only new cause", brk_cause_o, 2'b10);
    resume();
    chk("R7 cleared", brk_o, 0);
  endtask

  task automatic t_step();
    wr(3'd6, 8'h00);
    cyc('0, 1'b0, 1'b1, 1'b0);
    chk("R5 step off ignores done", brk_o, 0);
    wr(3'd6, 8'h01);
    cyc('0, 1'b0, 1'b1, 1'b0);
    chk("R5 step brk", brk_o, 1);
    chk("R5 step flag", brk_step_o, 1);
    resume();
    cyc('0, 1'b0, 1'b0, 1'b0);
    chk("R5 waits for next done", brk_o, 0);
    cyc('0, 1'b0, 1'b1, 1'b0);
    chk("R5 second step", brk_o, 1);
    resume();
  endtask

  task automatic t_accum();
    wr(3'd6, 8'h09);                      // en0 + step
    cyc(24'h123456, 1'b1, 1'b0, 1'b0);
    chk("R8 cmp0 only", {brk_step_o, brk_cause_o}, 3'b001);
    cyc('0, 1'b0, 1'b1, 1'b0);
    chk("R8 accumulated", {brk_step_o, brk_cause_o}, 3'b101);
    resume();
    chk("R8 cleared", {brk_o, brk_step_o, brk_cause_o}, 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_full();
    t_fetch();
    t_page();
    t_mask_pos();
    t_both_hold();
    t_step();
    t_accum();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule